// File: doc/BRIEF.md
# Four-Slot Address Breakpoint Comparator

This block watches the stream of memory accesses and instruction fetches that a processor core issues and compares each one against four programmable breakpoint slots. Each slot holds a watch address, an access-type code and a length code, and it is armed by a pair of enable bits: one local, one global. When an accepted access satisfies an armed slot, the block latches that slot's bit in a sticky status register and raises a one-cycle debug-exception pulse for the core's trap logic.

Software reaches the four address registers, the control register and the status register through a small register port with a combinational read path. A task-switch strobe from the core disarms every local enable in one cycle and leaves the global enables as they were. Accesses arrive on a valid/ready interface. The block never applies back-pressure: `acc_ready` is high in every cycle after reset, and an access is examined in exactly the cycle in which `acc_valid` and `acc_ready` are both high. There is no payload to hold, so nothing is queued.

The register port uses these select codes on `reg_sel`: 0 to 3 pick the four slot address registers, 4 picks the control register, and 5 picks the status register. Codes 6 and 7 read as zero, and writes to them are dropped. The encoding of `acc_kind` is 00 for an instruction fetch, 01 for a data read, 10 for a data write and 11 for a reserved kind. `acc_size` gives the access width as a power of two: 00 is 1 byte, 01 is 2, 10 is 4 and 11 is 8.

Top module: `bkpt_watch_unit`

## Requirements
- R1: Reset clears all registers to zero. Select codes 0 to 3 write and read back the four slot address registers. Reads of select codes 6 and 7 return zero.
- R2: In the control register, bit 2i is slot i's local enable and bit 2i+1 is its global enable. Bits 16+4i to 19+4i form slot i's field group: the type code is in the low two bits of the group and the length code in the high two. Bits 8 to 15 read as zero whatever is written to them.
- R3: A slot is armed when its local enable or its global enable is set. An unarmed slot never hits.
- R4: Type code 00 (execute) hits only on a fetch (`acc_kind` 00) whose address equals the slot address exactly, and only when the slot's length code is 00.
- R5: Type code 01 (write watch) hits only on data writes (`acc_kind` 10) that overlap the watched range.
- R6: Type code 11 (read/write watch) hits on data reads or writes that overlap the watched range, and never on a fetch. The reserved access kind 11 never hits any slot.
- R7: Type code 10 never produces a hit.
- R8: Length code 00 watches 1 byte, 01 watches 2, 10 watches 8 and 11 watches 4. The watched range starts at the slot address with its low bits cleared to that length's alignment. An access covers addr to addr+2^size-1, and a data slot hits when the two byte ranges share at least one byte. The range arithmetic does not wrap.
- R9: A hit sets the status bit of the hitting slot (bit i for slot i) and drives `dbg_exc` high for exactly the one cycle that follows the clock edge accepting the access.
- R10: Status bits are sticky, and no hardware event clears them. A write with select code 5 loads the status register. If hits occur in the same cycle as that write, their bits are ORed into the written value.
- R11: When several slots hit the same access, all of their status bits are set on the same clock edge.
- R12: A task-switch strobe clears every local enable and leaves the global enables unchanged. When it coincides with a control-register write, the written global enables and fields take effect and the local enables end up cleared.
- R13: `acc_ready` is high in every cycle after reset. An access with `acc_valid` low is not compared and causes neither a pulse nor a status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access present this cycle |
| acc_ready | output | 1 | Access accepted; high in every cycle after reset |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 reserved |
| acc_addr | input | AW (32) | Byte address of the access |
| acc_size | input | 2 | log2 of the access width in bytes |
| reg_en | input | 1 | Register port strobe |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_sel | input | SELW (3) | Register select code |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data; zero when no read is in progress |
| task_switch | input | 1 | Strobe that clears the local enables |
| dbg_exc | output | 1 | One-cycle debug-exception pulse |

## Verification
The hardest behaviour to reach from the ports is the exact edge of the overlap test. This covers a misaligned slot address whose watched window is pulled down to an aligned base, together with wide accesses that start just below that base or end just past it. The stimulus sweeps a single slot over every type code, every length code, every access kind and every access size, at each byte address from eight below the window to sixteen above it. The bench works out the expected hit arithmetically for each point. Two more situations need cycle-aligned stimulus: a status write landing on the same edge as a multi-slot hit, and a task-switch strobe landing on the same edge as a control write. The bench drives both halves of each pair in the same cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    BT_EXEC  = 2'b00,
    BT_WRITE = 2'b01,
    BT_IO    = 2'b10,
    BT_RDWR  = 2'b11
  } bt_kind_e;

  typedef enum logic [1:0] {
    AK_FETCH = 2'b00,
    AK_READ  = 2'b01,
    AK_WRITE = 2'b10,
    AK_RSVD  = 2'b11
  } acc_kind_e;

  // low-bit mask of a watched window; the length code is not monotonic
  function automatic logic [2:0] span_mask(input logic [1:0] len);
    case (len)
      2'b00:   span_mask = 3'd0;
      2'b01:   span_mask = 3'd1;
      2'b10:   span_mask = 3'd7;
      default: span_mask = 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/bkpt_slot_match.sv
module bkpt_slot_match
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          armed,
  input  logic          fire,
  input  logic [AW-1:0] slot_addr,
  input  logic [1:0]    typ,
  input  logic [1:0]    len,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  output logic          hit
);

  localparam int XW = AW + 1;

  logic [AW-1:0] lmask, base;
  logic [XW-1:0] wend, aend;
  logic          ovl, type_ok;

  always_comb begin
    lmask = AW'(span_mask(len));
    base  = slot_addr & ~lmask;
    // one extra bit so a window at the top of the space does not wrap
    wend  = {1'b0, base} + {1'b0, lmask} + XW'(1);
    aend  = {1'b0, acc_addr} + (XW'(1) << acc_size);
    ovl   = ({1'b0, acc_addr} < wend) && ({1'b0, base} < aend);
    case (bt_kind_e'(typ))
      BT_EXEC:  type_ok = (kind == AK_FETCH) && (len == 2'b00) && (acc_addr == slot_addr);
      BT_WRITE: type_ok = (kind == AK_WRITE) && ovl;
      BT_RDWR:  type_ok = ((kind == AK_READ) || (kind == AK_WRITE)) && ovl;
      default:  type_ok = 1'b0;
    endcase
    hit = armed && fire && type_ok;
  end

endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SELW  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_en,
  input  logic                       reg_we,
  input  logic [SELW-1:0]            reg_sel,
  input  logic [DW-1:0]              reg_wdata,
  output logic [DW-1:0]              reg_rdata,
  input  logic                       task_switch,
  input  logic [NSLOT-1:0]           hit_vec,
  output logic [NSLOT-1:0][AW-1:0]   slot_addr,
  output logic [NSLOT-1:0]           slot_armed,
  output logic [NSLOT-1:0][1:0]      slot_typ,
  output logic [NSLOT-1:0][1:0]      slot_len,
  output logic [DW-1:0]              ctl_word,
  output logic [NSLOT-1:0]           sts_word
);

  localparam int SEL_CTL = NSLOT;
  localparam int SEL_STS = NSLOT + 1;
  localparam int FLD_LSB = 16;

  logic [NSLOT-1:0][AW-1:0] adr_q;
  logic [NSLOT-1:0][3:0]    fld_q;
  logic [NSLOT-1:0]         loc_q, glb_q, sts_q;
  logic                     wr;

  assign wr = reg_en && reg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_q <= '0;
      fld_q <= '0;
      loc_q <= '0;
      glb_q <= '0;
      sts_q <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (wr && reg_sel == SELW'(i)) adr_q[i] <= reg_wdata[AW-1:0];
        if (wr && reg_sel == SELW'(SEL_CTL)) begin
          loc_q[i] <= reg_wdata[2*i];
          glb_q[i] <= reg_wdata[2*i+1];
          fld_q[i] <= reg_wdata[FLD_LSB+4*i +: 4];
        end
      end
      if (task_switch) loc_q <= '0;
      sts_q <= ((wr && reg_sel == SELW'(SEL_STS)) ? reg_wdata[NSLOT-1:0] : sts_q) | hit_vec;
    end
  end

  always_comb begin
    ctl_word = '0;
    for (int i = 0; i < NSLOT; i++) begin
      ctl_word[2*i]                 = loc_q[i];
      ctl_word[2*i+1]               = glb_q[i];
      ctl_word[FLD_LSB+4*i +: 4]    = fld_q[i];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_we) begin
      for (int i = 0; i < NSLOT; i++)
        if (reg_sel == SELW'(i)) reg_rdata = DW'(adr_q[i]);
      if (reg_sel == SELW'(SEL_CTL)) reg_rdata = ctl_word;
      if (reg_sel == SELW'(SEL_STS)) reg_rdata = DW'(sts_q);
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_out
    assign slot_addr[g]  = adr_q[g];
    assign slot_armed[g] = loc_q[g] | glb_q[g];
    assign slot_typ[g]   = fld_q[g][1:0];
    assign slot_len[g]   = fld_q[g][3:2];
  end

  assign sts_word = sts_q;

endmodule

// File: rtl/bkpt_watch_unit.sv
module bkpt_watch_unit
  import bkpt_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SELW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic [1:0]      acc_kind,
  input  logic [AW-1:0]   acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [SELW-1:0] reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            task_switch,
  output logic            dbg_exc
);

  logic                     rdy_q, exc_q, acc_fire;
  logic [NSLOT-1:0][AW-1:0] slot_addr;
  logic [NSLOT-1:0][1:0]    slot_typ, slot_len;
  logic [NSLOT-1:0]         slot_armed, slot_hit, sts_q;
  logic [DW-1:0]            ctl_q;

  assign acc_fire = acc_valid && rdy_q;

  bkpt_regs #(.NSLOT(NSLOT), .AW(AW), .DW(DW), .SELW(SELW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .task_switch(task_switch),
    .hit_vec    (slot_hit),
    .slot_addr  (slot_addr),
    .slot_armed (slot_armed),
    .slot_typ   (slot_typ),
    .slot_len   (slot_len),
    .ctl_word   (ctl_q),
    .sts_word   (sts_q)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    bkpt_slot_match #(.AW(AW)) u_match (
      .armed    (slot_armed[g]),
      .fire     (acc_fire),
      .slot_addr(slot_addr[g]),
      .typ      (slot_typ[g]),
      .len      (slot_len[g]),
      .kind     (acc_kind),
      .acc_addr (acc_addr),
      .acc_size (acc_size),
      .hit      (slot_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      exc_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      exc_q <= |slot_hit;
    end
  end

  assign acc_ready = rdy_q;
  assign dbg_exc   = exc_q;

endmodule

// File: rtl/bkpt_watch_chk.sv
module bkpt_watch_chk #(
  parameter int NSLOT = 4,
  parameter int DW    = 32,
  parameter int SELW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            task_switch,
  input logic            reg_en,
  input logic            reg_we,
  input logic [SELW-1:0] reg_sel,
  input logic            dbg_exc,
  input logic [DW-1:0]   ctl_q,
  input logic [NSLOT-1:0] sts_q,
  input logic [NSLOT-1:0] slot_hit
);

  function automatic logic [DW-1:0] enable_mask(input int odd);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NSLOT; i++) m[2*i+odd] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] LMASK = enable_mask(0);
  localparam logic [DW-1:0] GMASK = enable_mask(1);

  logic sts_wr, ctl_wr;
  assign sts_wr = reg_en && reg_we && (reg_sel == SELW'(NSLOT + 1));
  assign ctl_wr = reg_en && reg_we && (reg_sel == SELW'(NSLOT));

  assert_pulse_needs_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> $past(acc_valid));

  assert_pulse_has_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> (sts_q != '0));

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_all_hits_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(slot_hit)) == $past(slot_hit)));

  assert_switch_clears_local_R12: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> ((ctl_q & LMASK) == '0));

  assert_switch_keeps_global_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !ctl_wr) |=> $stable(ctl_q & GMASK));

  assert_idle_no_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !dbg_exc);

  for (genvar g = 0; g < NSLOT; g++) begin : g_io
    assert_io_type_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[16+4*g +: 2] == 2'b10) |-> !slot_hit[g]);
  end

endmodule

bind bkpt_watch_unit bkpt_watch_chk #(.NSLOT(NSLOT), .DW(DW), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .task_switch(task_switch),
  .reg_en     (reg_en),
  .reg_we     (reg_we),
  .reg_sel    (reg_sel),
  .dbg_exc    (dbg_exc),
  .ctl_q      (ctl_q),
  .sts_q      (sts_q),
  .slot_hit   (slot_hit)
);

// File: tb/sim_bkpt_watch_unit.sv
`timescale 1ns/1ps
module sim_bkpt_watch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [1:0]  acc_kind = 2'b00;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = 2'b00;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        task_switch = 1'b0;
  logic        dbg_exc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bkpt_watch_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_size(acc_size),
    .reg_en(reg_en), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .task_switch(task_switch), .dbg_exc(dbg_exc)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_size = s;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_sel = sel;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  function automatic bit exp_hit(input int typ, input int len, input longint saddr,
                                 input int kind, input longint a, input int sz);
    longint lb, base;
    bit ov;
    lb = (len == 0) ? 1 : (len == 1) ? 2 : (len == 2) ? 8 : 4;
    base = saddr - (saddr % lb);
    ov = (a < base + lb) && (base < a + (longint'(1) << sz));
    case (typ)
      0: return (kind == 0) && (len == 0) && (a == saddr);
      1: return (kind == 2) && ov;
      3: return ((kind == 1) || (kind == 2)) && ov;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int typ);
    case (typ)
      0: return "R4/R8";
      1: return "R5/R8";
      2: return "R7";
      default: return "R6/R8";
    endcase
  endfunction

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk("R13", "acc_ready after reset", acc_ready, 1);
    chk("R9", "dbg_exc after reset", dbg_exc, 0);
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), d);
      chk(s < 4 ? "R1" : (s == 4 ? "R2" : "R10"), "reset value", d, 0);
    end

    // R1 address registers
    for (int s = 0; s < 4; s++) wr(3'(s), 32'hA500_0000 + 32'(s) * 32'h111);
    for (int s = 0; s < 4; s++) begin
      rd(3'(s), d);
      chk("R1", "address readback", d, 32'hA500_0000 + 32'(s) * 32'h111);
    end
    wr(3'd6, 32'hDEAD_BEEF);
    rd(3'd6, d);
    chk("R1", "unused select reads zero", d, 0);

    // R2 control layout
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d);
    chk("R2", "control unused bits", d, 32'hFFFF_00FF);

    // R12 task switch alone and with a coincident control write
    @(negedge clk); task_switch = 1'b1;
    @(negedge clk); task_switch = 1'b0;
    rd(3'd4, d);
    chk("R12", "switch clears local only", d, 32'hFFFF_00AA);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h0000_00FF; task_switch = 1'b1;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; task_switch = 1'b0;
    rd(3'd4, d);
    chk("R12", "switch with control write", d, 32'h0000_00AA);
    wr(3'd4, 32'h0);

    // R3 local-only enable arms a slot, no enable disarms it
    wr(3'd1, 32'h40);
    wr(3'd4, (32'h3 << 20) | 32'h4);
    access(2'b01, 32'h40, 2'b00);
    chk("R3", "local enable pulse", dbg_exc, 1);
    rd(3'd5, d);
    chk("R3", "local enable status", d, 32'h2);
    wr(3'd5, 32'h0);
    wr(3'd4, (32'h3 << 20));
    access(2'b01, 32'h40, 2'b00);
    chk("R3", "unarmed pulse", dbg_exc, 0);
    rd(3'd5, d);
    chk("R3", "unarmed status", d, 0);

    // R13 matching fields with valid low
    wr(3'd4, (32'h3 << 20) | 32'h8);
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'b01; acc_addr = 32'h40; acc_size = 2'b00;
    @(negedge clk);
    chk("R13", "idle pulse", dbg_exc, 0);
    rd(3'd5, d);
    chk("R13", "idle status", d, 0);

    // sweep one slot over every type, length, kind, size and nearby address
    wr(3'd0, 32'h1005);
    for (int typ = 0; typ < 4; typ++) begin
      for (int len = 0; len < 4; len++) begin
        wr(3'd4, 32'h2 | (32'(typ) << 16) | (32'(len) << 18));
        for (int kind = 0; kind < 4; kind++) begin
          for (int sz = 0; sz < 4; sz++) begin
            for (int off = -8; off <= 16; off++) begin
              bit e;
              e = exp_hit(typ, len, 64'h1005, kind, 64'h1000 + longint'(off), sz);
              access(2'(kind), 32'(32'h1000 + off), 2'(sz));
              chk(tag_of(typ), "sweep pulse", dbg_exc, longint'(e));
              rd(3'd5, d);
              chk(tag_of(typ), "sweep status", d, longint'(e));
              if (d != 0) wr(3'd5, 32'h0);
            end
          end
        end
      end
    end

    // R11 several slots on one access, R9 pulse width, R10 accumulation
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h200);
    wr(3'd1, 32'h202);
    wr(3'd2, 32'h300);
    wr(3'd3, 32'h204);
    wr(3'd4, 32'hBF7F_00AA);
    access(2'b10, 32'h202, 2'b01);
    chk("R9", "pulse on multi hit", dbg_exc, 1);
    rd(3'd5, d);
    chk("R11", "multi-slot status", d, 32'hB);
    chk("R9", "pulse lasts one cycle", dbg_exc, 0);
    access(2'b10, 32'h300, 2'b00);
    rd(3'd5, d);
    chk("R10", "status accumulates", d, 32'hF);
    wr(3'd5, 32'h4);
    rd(3'd5, d);
    chk("R10", "software load", d, 32'h4);
    wr(3'd5, 32'h0);
    rd(3'd5, d);
    chk("R10", "software clear", d, 0);

    // R10 status write coinciding with a hit
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 32'h4;
    acc_valid = 1'b1; acc_kind = 2'b10; acc_addr = 32'h202; acc_size = 2'b01;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; acc_valid = 1'b0;
    chk("R9", "pulse with status write", dbg_exc, 1);
    rd(3'd5, d);
    chk("R10", "hit ORed into write", d, 32'hF);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule